// File: doc/BRIEF.md
# Relative and Indexed Address Generator

This unit forms word addresses for data accesses from a short signed displacement carried in an instruction and a set of register values held by the surrounding processor: the program counter, a base (record) pointer, an index register and a byte-index register. A two-bit mode picks the base. The base can be the program counter, the base pointer or the index register. The fourth mode adds the base pointer, the displacement and the index together, so that code can reach one element of an array that sits inside a record. The displacement is sign-extended, so an access can reach words on either side of the base pointer.

Memory is addressed only in whole words, two bytes each. For string handling the unit can also perform byte accesses. It takes the effective address from the selected mode as the string start. It adds the byte index halved to give the word address, and uses the low bit of the byte index to pick a lane. A byte read fetches the word and returns the selected byte. A byte write performs a read-modify-write: it fetches the word, replaces only the selected lane and writes the word back. A one-cycle result strobe marks the end of both kinds of byte access.

Top module: `agu_rel_index`

## Requirements
- R1: Mode 00 gives an effective address of P plus the sign-extended displacement.
- R2: Mode 01 gives B plus the sign-extended displacement.
- R3: Mode 10 gives X plus the sign-extended displacement.
- R4: Mode 11 gives B plus X plus the sign-extended displacement.
- R5: The displacement is a DISP_W-bit two's-complement field. A set top bit gives a negative offset, so the reach runs from -2^(DISP_W-1) to 2^(DISP_W-1)-1 words around the base.
- R6: All sums wrap modulo 2^ADDR_W, and no flag or other output reports the wrap.
- R7: An accepted request (req_valid and req_ready both high at an edge) gives ea_valid high with ea_addr in the next cycle, for that one cycle only. req_ready is low while a byte access is in flight. A request made while req_ready is low is ignored and produces no ea_valid.
- R8: For a byte access, ea_addr and mem_addr equal the mode's effective address plus the byte index T shifted right by one. mem_rd is high for exactly the cycle after acceptance.
- R9: ea_lane equals T bit 0. Lane 0 is the high byte (bits DATA_W-1 down to DATA_W/2) and lane 1 is the low byte.
- R10: The memory returns read data in the cycle after mem_rd. Two cycles after mem_rd, res_valid is high for one cycle and res_byte holds the selected lane of the word that was read. For writes, res_byte holds the byte being replaced.
- R11: On a byte write, mem_we is high in the same cycle as res_valid, at the same mem_addr. mem_wdata holds the new byte in the selected lane and leaves the other lane as it was read.
- R12: After reset, req_ready is high and ea_valid, mem_rd, mem_we and res_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Address request |
| req_ready | output | 1 | Unit can accept a request |
| req_mode | input | 2 | Address mode: 00 P, 01 B, 10 X, 11 B+X |
| req_disp | input | DISP_W | Signed displacement field |
| req_byte | input | 1 | Request is a byte access |
| req_write | input | 1 | Byte access is a write |
| req_wbyte | input | DATA_W/2 | Byte to store |
| reg_p | input | ADDR_W | Program counter value |
| reg_b | input | ADDR_W | Base pointer value |
| reg_x | input | ADDR_W | Index register value |
| reg_t | input | ADDR_W | Byte index value |
| ea_valid | output | 1 | Address result strobe |
| ea_addr | output | ADDR_W | Computed word address |
| ea_lane | output | 1 | Byte lane of a byte access |
| mem_rd | output | 1 | Word read strobe |
| mem_we | output | 1 | Word write strobe |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Merged word to store |
| mem_rdata | input | DATA_W | Word read data, one cycle after mem_rd |
| res_valid | output | 1 | Byte access complete |
| res_byte | output | DATA_W/2 | Byte read from the selected lane |

## Verification
The bench builds the unit with ADDR_W = 10 and DISP_W = 6. At that size every displacement value can be swept in all four modes, against base values at zero, in the middle and near the top of the 1024-word space. The top-end bases make the modulo wrap in both directions easy to reach. It covers a 64-entry byte-index range with a 1024-word memory model, alternating reads and writes. It then reads back each written word through the unit, which shows whether the untouched lane survived.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [1:0] {
    MODE_PREL  = 2'b00,
    MODE_BREL  = 2'b01,
    MODE_XREL  = 2'b10,
    MODE_BXREL = 2'b11
  } agu_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_DATA = 2'd2
  } agu_state_e;
endpackage

// File: rtl/agu_disp_ext.sv
module agu_disp_ext #(
  parameter int DISP_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic [DISP_W-1:0] disp,
  output logic [ADDR_W-1:0] disp_ext
);
  localparam int PAD_W = ADDR_W - DISP_W;

  generate
    if (PAD_W > 0) begin : g_pad
      assign disp_ext = {{PAD_W{disp[DISP_W-1]}}, disp};
    end else begin : g_trim
      assign disp_ext = disp[ADDR_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/agu_ea_calc.sv
module agu_ea_calc
  import agu_pkg::*;
#(
  parameter int DISP_W = 8,
  parameter int ADDR_W = 16
) (
  input  agu_mode_e         mode,
  input  logic [DISP_W-1:0] disp,
  input  logic [ADDR_W-1:0] reg_p,
  input  logic [ADDR_W-1:0] reg_b,
  input  logic [ADDR_W-1:0] reg_x,
  input  logic [ADDR_W-1:0] reg_t,
  output logic [ADDR_W-1:0] ea,
  output logic [ADDR_W-1:0] byte_word,
  output logic              byte_lane
);
  logic [ADDR_W-1:0] disp_ext;
  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] index;
  logic [ADDR_W-1:0] t_half;

  agu_disp_ext #(.DISP_W(DISP_W), .ADDR_W(ADDR_W)) i_ext (
    .disp     (disp),
    .disp_ext (disp_ext)
  );

  always_comb begin
    base  = reg_b;
    index = '0;
    unique case (mode)
      MODE_PREL:  base = reg_p;
      MODE_BREL:  base = reg_b;
      MODE_XREL:  base = reg_x;
      MODE_BXREL: begin
        base  = reg_b;
        index = reg_x;
      end
      default:    base = reg_b;
    endcase
  end

  assign ea        = base + disp_ext + index;
  assign t_half    = {1'b0, reg_t[ADDR_W-1:1]};
  assign byte_word = ea + t_half;
  assign byte_lane = reg_t[0];
endmodule

// File: rtl/agu_lane_unit.sv
module agu_lane_unit #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0]   word_in,
  input  logic                lane,
  input  logic [DATA_W/2-1:0] new_byte,
  output logic [DATA_W/2-1:0] byte_out,
  output logic [DATA_W-1:0]   word_merged
);
  localparam int BYTE_W = DATA_W / 2;
  localparam int LANES  = 2;

  logic [BYTE_W-1:0] piece [LANES];

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      assign piece[g] = word_in[(LANES-1-g)*BYTE_W +: BYTE_W];
      assign word_merged[(LANES-1-g)*BYTE_W +: BYTE_W] =
        (lane == g[0]) ? new_byte : piece[g];
    end
  endgenerate

  assign byte_out = piece[lane];
endmodule

// File: rtl/agu_rel_index.sv
module agu_rel_index
  import agu_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DISP_W = 8,
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [1:0]          req_mode,
  input  logic [DISP_W-1:0]   req_disp,
  input  logic                req_byte,
  input  logic                req_write,
  input  logic [DATA_W/2-1:0] req_wbyte,
  input  logic [ADDR_W-1:0]   reg_p,
  input  logic [ADDR_W-1:0]   reg_b,
  input  logic [ADDR_W-1:0]   reg_x,
  input  logic [ADDR_W-1:0]   reg_t,
  output logic                ea_valid,
  output logic [ADDR_W-1:0]   ea_addr,
  output logic                ea_lane,
  output logic                mem_rd,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_wdata,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic                res_valid,
  output logic [DATA_W/2-1:0] res_byte
);
  localparam int BYTE_W = DATA_W / 2;

  agu_state_e        state;
  logic [ADDR_W-1:0] ea_comb;
  logic [ADDR_W-1:0] bw_comb;
  logic              lane_comb;
  logic              op_write;
  logic              op_lane;
  logic [BYTE_W-1:0] op_wbyte;
  logic [BYTE_W-1:0] lane_byte;
  logic [DATA_W-1:0] merged;
  logic              accept;

  agu_ea_calc #(.DISP_W(DISP_W), .ADDR_W(ADDR_W)) i_calc (
    .mode      (agu_mode_e'(req_mode)),
    .disp      (req_disp),
    .reg_p     (reg_p),
    .reg_b     (reg_b),
    .reg_x     (reg_x),
    .reg_t     (reg_t),
    .ea        (ea_comb),
    .byte_word (bw_comb),
    .byte_lane (lane_comb)
  );

  agu_lane_unit #(.DATA_W(DATA_W)) i_lane (
    .word_in     (mem_rdata),
    .lane        (op_lane),
    .new_byte    (op_wbyte),
    .byte_out    (lane_byte),
    .word_merged (merged)
  );

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      ea_valid  <= 1'b0;
      ea_addr   <= '0;
      ea_lane   <= 1'b0;
      mem_rd    <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      res_valid <= 1'b0;
      res_byte  <= '0;
      op_write  <= 1'b0;
      op_lane   <= 1'b0;
      op_wbyte  <= '0;
    end else begin
      ea_valid  <= accept;
      mem_rd    <= 1'b0;
      mem_we    <= 1'b0;
      res_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            if (req_byte) begin
              ea_addr  <= bw_comb;
              ea_lane  <= lane_comb;
              mem_addr <= bw_comb;
              mem_rd   <= 1'b1;
              op_write <= req_write;
              op_lane  <= lane_comb;
              op_wbyte <= req_wbyte;
              state    <= ST_WAIT;
            end else begin
              ea_addr <= ea_comb;
              ea_lane <= 1'b0;
            end
          end
        end
        ST_WAIT: state <= ST_DATA;
        ST_DATA: begin
          res_valid <= 1'b1;
          res_byte  <= lane_byte;
          if (op_write) begin
            mem_we    <= 1'b1;
            mem_wdata <= merged;
          end
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7: address strobe follows acceptance by one cycle
  a_r7_ea_after_accept: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> ea_valid);
  a_r7_no_ea_without_accept: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_ready) |=> !ea_valid);
  // R7: no new request accepted while a word read is outstanding
  a_r7_busy_on_read: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> !req_ready);
  // R8: the read strobe is a single cycle
  a_r8_rd_pulse: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> !mem_rd);
  // R10: result two cycles after the read strobe
  a_r10_result_timing: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> ##2 res_valid);
  // R11: write strobe only with result, at the fetched address
  a_r11_we_with_result: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (res_valid && $stable(mem_addr)));
  // R11: untouched lane equals the word that was read
  a_r11_keep_lane: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (op_lane ? (mem_wdata[DATA_W-1 -: BYTE_W] == $past(mem_rdata[DATA_W-1 -: BYTE_W]))
                        : (mem_wdata[BYTE_W-1:0] == $past(mem_rdata[BYTE_W-1:0]))));
endmodule

// File: tb/test_agu_rel_index.sv
module test_agu_rel_index;
  localparam int AW = 10;
  localparam int DW = 6;
  localparam int WW = 16;
  localparam int BW = 8;
  localparam int AM = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_byte = 1'b0, req_write = 1'b0;
  logic [1:0] req_mode = '0;
  logic [DW-1:0] req_disp = '0;
  logic [BW-1:0] req_wbyte = '0;
  logic [AW-1:0] reg_p = '0, reg_b = '0, reg_x = '0, reg_t = '0;
  logic req_ready, ea_valid, ea_lane, mem_rd, mem_we, res_valid;
  logic [AW-1:0] ea_addr, mem_addr;
  logic [WW-1:0] mem_wdata, mem_rdata;
  logic [BW-1:0] res_byte;

  logic [WW-1:0] mem [AM];
  logic [WW-1:0] shadow [AM];
  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  agu_rel_index #(.ADDR_W(AW), .DISP_W(DW), .DATA_W(WW)) i_agu_rel_index (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_disp(req_disp), .req_byte(req_byte),
    .req_write(req_write), .req_wbyte(req_wbyte), .reg_p(reg_p),
    .reg_b(reg_b), .reg_x(reg_x), .reg_t(reg_t), .ea_valid(ea_valid),
    .ea_addr(ea_addr), .ea_lane(ea_lane), .mem_rd(mem_rd), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .res_valid(res_valid), .res_byte(res_byte)
  );

  initial begin
    for (int i = 0; i < AM; i++) begin
      mem[i]    = WW'((i * 97 + 13) ^ (i << 7));
      shadow[i] = mem[i];
    end
  end

  always_ff @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr];
    if (mem_we) mem[mem_addr] <= mem_wdata;
  end

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      summary();
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int ea_model(input int mode, input int d, input int p,
                                   input int b, input int x);
    int sd = (d >= (1 << (DW-1))) ? d - (1 << DW) : d;
    int s;
    case (mode)
      0: s = p + sd;
      1: s = b + sd;
      2: s = x + sd;
      default: s = b + x + sd;
    endcase
    return ((s % AM) + AM) % AM;
  endfunction

  function automatic string mode_tag(input int mode);
    case (mode)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic word_req(input int mode, input int d, input int p, input int b, input int x);
    int exp;
    @(negedge clk);
    req_valid = 1'b1; req_byte = 1'b0; req_write = 1'b0;
    req_mode = 2'(mode); req_disp = DW'(d);
    reg_p = AW'(p); reg_b = AW'(b); reg_x = AW'(x);
    @(negedge clk);
    req_valid = 1'b0;
    exp = ea_model(mode, d, p, b, x);
    // R5 R6: signed offset and modulo wrap are inside the model
    check(ea_valid && (int'(ea_addr) == exp), mode_tag(mode), int'(ea_addr), exp);
  endtask

  task automatic byte_req(input int mode, input int d, input int b, input int x,
                          input int t, input bit wr, input int wb, input bit poke);
    int wa, lane, old, expb, expw;
    @(negedge clk);
    req_valid = 1'b1; req_byte = 1'b1; req_write = wr;
    req_mode = 2'(mode); req_disp = DW'(d); req_wbyte = BW'(wb);
    reg_p = '0; reg_b = AW'(b); reg_x = AW'(x); reg_t = AW'(t);
    wa   = (ea_model(mode, d, 0, b, x) + (t >> 1)) % AM;
    lane = t & 1;
    old  = int'(shadow[wa]);
    expb = (lane == 0) ? ((old >> BW) & 8'hFF) : (old & 8'hFF);
    expw = (lane == 0) ? (((wb & 8'hFF) << BW) | (old & 8'hFF))
                       : ((old & 16'hFF00) | (wb & 8'hFF));
    @(negedge clk);
    check(ea_valid && mem_rd && (int'(mem_addr) == wa) && (int'(ea_addr) == wa),
          "R8", int'(mem_addr), wa);
    check(int'(ea_lane) == lane, "R9", int'(ea_lane), lane);
    check(!req_ready, "R7", int'(req_ready), 0);
    req_valid = poke;
    req_mode = 2'(3 - mode);
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) check(!ea_valid && !mem_rd, "R7", int'(ea_valid), 0);
    @(negedge clk);
    if (poke) check(!ea_valid, "R7", int'(ea_valid), 0);
    check(res_valid && (int'(res_byte) == expb), "R10", int'(res_byte), expb);
    if (wr) begin
      check(mem_we && (int'(mem_addr) == wa) && (int'(mem_wdata) == expw),
            "R11", int'(mem_wdata), expw);
      shadow[wa] = WW'(expw);
    end else begin
      check(!mem_we, "R11", int'(mem_we), 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(req_ready && !ea_valid && !mem_rd && !mem_we && !res_valid, "R12",
          {req_ready, ea_valid, mem_rd, mem_we, res_valid}, 5'b10000);

    for (int m = 0; m < 4; m++) begin
      for (int d = 0; d < (1 << DW); d++) begin
        word_req(m, d, 5, 3, 7);
        word_req(m, d, 512, 300, 211);
        word_req(m, d, AM - 3, AM - 20, 30);
        word_req(m, d, 1, AM - 1, AM - 2);
      end
    end

    // R5: extremes of the displacement field
    word_req(1, 1 << (DW-1), 100, 100, 0);
    word_req(1, (1 << (DW-1)) - 1, 100, 100, 0);

    for (int t = 0; t < 64; t++) begin
      byte_req(t % 4, (t * 5) % (1 << DW), 40 + t, 3 * t, t, t[0] ^ t[1], (t * 29 + 7) & 8'hFF, t[2]);
    end
    // read back every touched word through the unit: R11 lane preservation
    for (int t = 0; t < 64; t++) begin
      byte_req(t % 4, (t * 5) % (1 << DW), 40 + t, 3 * t, t ^ 1, 1'b0, 0, 1'b0);
      byte_req(t % 4, (t * 5) % (1 << DW), 40 + t, 3 * t, t, 1'b0, 0, 1'b0);
    end
    // R6: byte address wrapping past the top of memory
    byte_req(1, 0, AM - 1, 0, 6, 1'b1, 8'hA5, 1'b0);
    byte_req(1, 0, AM - 1, 0, 7, 1'b0, 0, 1'b0);

    repeat (2) @(negedge clk);
    summary();
  end
endmodule